// File: doc/BRIEF.md
# Audio Frame Sequencer with Regional Timing

The block drives the slow housekeeping clocks of a retro console sound unit. Counting CPU clocks, it walks through a fixed list of steps. At each step it emits a one-cycle quarter-frame pulse, which clocks the envelopes and the triangle linear counter, and on some steps a half-frame pulse, which clocks the length counters and sweep units. In four-step mode it also raises a sticky frame interrupt flag. The gaps between steps are uneven, and the region input picks one of two sets of gaps: 60 Hz or 50 Hz.

Software writes a mode byte. Bit 7 selects five-step mode and bit 6 inhibits the interrupt. Every write restarts the sequence after a mode-dependent start-up delay. A status read drives `irq_ack` and clears the flag, except while the flag is being asserted.

The step tracker is a state machine whose state names the next step to fire. In four-step mode the transitions are STEP1→STEP2, STEP2→STEP3, STEP3→STEP4 and STEP4→STEP1. In five-step mode they are STEP1→STEP2, STEP2→STEP3, STEP3→STEP4, STEP4→STEP5 and STEP5→STEP1. A mode write or reset forces STEP1.

Top module: `fseq_top`

## Requirements
- R1: In four-step mode the first step fires 7459 clocks after the mode write with `pal_sel`=0, or 8315 with `pal_sel`=1. The gaps after steps 1,2,3,4 are 7456,7458,7458,7458 (60 Hz) or 8314,8312,8314,8314 (50 Hz), and step 4 is followed by step 1.
- R2: In four-step mode every step pulses `qtr_pulse`, and steps 2 and 4 also pulse `half_pulse`.
- R3: With bit 7 of `mode_data` set, step 1 fires 1 clock after the write. The gaps after steps 1..5 are 7458,7456,7458,7458,7452 (60 Hz) or 8314,8314,8312,8314,8312 (50 Hz), and step 5 is followed by step 1.
- R4: In five-step mode steps 1..4 pulse `qtr_pulse` and steps 1 and 3 also pulse `half_pulse`. Step 5 pulses nothing, and `irq_flag` is never set.
- R5: In four-step mode with interrupts enabled, the flag is set on three consecutive edges. These are the edge one clock before step 4 fires, the step-4 edge and the next edge. The flag stays set until `irq_ack`, and an `irq_ack` on any of those three edges has no effect.
- R6: Bit 6 of `mode_data` inhibits the interrupt. A write with it set clears a pending flag on the write edge, and the flag stays clear through the sequence.
- R7: A mode write mid-sequence discards the current position and restarts from step 1 with the start-up delay of the new mode.
- R8: Reset acts like a write of 0x00 taken at the last reset edge. While in reset all outputs are low.
- R9: `pal_sel` is sampled only during reset and on a mode write. Changing it at any other time does not alter the running schedule.
- R10: Each pulse lasts one clock, and `half_pulse` only occurs together with `qtr_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_sel | input | 1 | Region select: 0 = 60 Hz gaps, 1 = 50 Hz gaps |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | 8 | Written byte: bit 7 five-step, bit 6 interrupt inhibit |
| irq_ack | input | 1 | Status read, clears the interrupt flag |
| qtr_pulse | output | 1 | Quarter-frame clock pulse |
| half_pulse | output | 1 | Half-frame clock pulse |
| irq_flag | output | 1 | Frame interrupt flag |

## Verification
The assertions take for granted that mode writes are never issued on two consecutive clocks. With back-to-back five-step writes a pulse could repeat, and the first-step property would be cut short. They also take for granted that `irq_ack` is a plain strobe with no timing relation to the writes. The stimulus keeps to this by issuing each write as a single-cycle strobe followed by thousands of idle cycles. It places `irq_ack` only on chosen edges around the step-4 point, well away from any write.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    parameter int CNT_W = 14;

    typedef enum logic [2:0] {
        STEP1, STEP2, STEP3, STEP4, STEP5
    } step_e;

    localparam int N_START4 = 7459;
    localparam int P_START4 = 8315;
    localparam int START5   = 1;
    localparam int N_GAP_A  = 7456;
    localparam int N_GAP_B  = 7458;
    localparam int N_GAP_C  = 7452;
    localparam int P_GAP_A  = 8314;
    localparam int P_GAP_B  = 8312;
endpackage

// File: rtl/fseq_delay_sel.sv
module fseq_delay_sel
    import fseq_pkg::*;
(
    input  logic             pal,
    input  logic             five,
    input  logic             start,
    input  step_e            fired,
    output logic [CNT_W-1:0] load_val
);
    int gap;

    always_comb begin
        gap = N_GAP_B;
        if (start) begin
            gap = five ? START5 : (pal ? P_START4 : N_START4);
        end else if (!five) begin
            unique case (fired)
                STEP1:   gap = pal ? P_GAP_A : N_GAP_A;
                STEP2:   gap = pal ? P_GAP_B : N_GAP_B;
                default: gap = pal ? P_GAP_A : N_GAP_B;
            endcase
        end else begin
            unique case (fired)
                STEP1:   gap = pal ? P_GAP_A : N_GAP_B;
                STEP2:   gap = pal ? P_GAP_A : N_GAP_A;
                STEP3:   gap = pal ? P_GAP_B : N_GAP_B;
                STEP4:   gap = pal ? P_GAP_A : N_GAP_B;
                default: gap = pal ? P_GAP_B : N_GAP_C;
            endcase
        end
        load_val = CNT_W'(gap - 1);
    end
endmodule

// File: rtl/fseq_irq_ctl.sv
module fseq_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic window,
    input  logic fire4,
    input  logic wr,
    input  logic wr_inhibit,
    input  logic ack,
    output logic flag
);
    logic tail_q;
    logic set_now;

    assign set_now = (window || tail_q) && !wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            tail_q <= fire4 && !wr;
            if (wr_inhibit)
                flag <= 1'b0;
            else if (set_now)
                flag <= 1'b1;
            else if (ack)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_sel,
    input  logic       mode_wr,
    input  logic [7:0] mode_data,
    input  logic       irq_ack,
    output logic       qtr_pulse,
    output logic       half_pulse,
    output logic       irq_flag
);
    localparam int MODE_BIT    = 7;
    localparam int INHIBIT_BIT = 6;

    step_e            step_q, step_d;
    logic [CNT_W-1:0] cnt_q;
    logic             five_q, inhib_q, pal_q;
    logic [CNT_W-1:0] rst_load, wr_load, gap_load;
    logic             fire, irq_ok;

    fseq_delay_sel u_rst_dly (
        .pal(pal_sel), .five(1'b0), .start(1'b1), .fired(STEP1), .load_val(rst_load)
    );
    fseq_delay_sel u_wr_dly (
        .pal(pal_sel), .five(mode_data[MODE_BIT]), .start(1'b1), .fired(STEP1),
        .load_val(wr_load)
    );
    fseq_delay_sel u_gap_dly (
        .pal(pal_q), .five(five_q), .start(1'b0), .fired(step_q), .load_val(gap_load)
    );

    assign fire   = !mode_wr && (cnt_q == '0);
    assign irq_ok = !five_q && !inhib_q && (step_q == STEP4);

    always_comb begin
        unique case (step_q)
            STEP1:   step_d = STEP2;
            STEP2:   step_d = STEP3;
            STEP3:   step_d = STEP4;
            STEP4:   step_d = five_q ? STEP5 : STEP1;
            default: step_d = STEP1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q  <= STEP1;
            cnt_q   <= rst_load;
            five_q  <= 1'b0;
            inhib_q <= 1'b0;
            pal_q   <= pal_sel;
        end else if (mode_wr) begin
            step_q  <= STEP1;
            cnt_q   <= wr_load;
            five_q  <= mode_data[MODE_BIT];
            inhib_q <= mode_data[INHIBIT_BIT];
            pal_q   <= pal_sel;
        end else if (cnt_q == '0) begin
            step_q <= step_d;
            cnt_q  <= gap_load;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qtr_pulse  <= 1'b0;
            half_pulse <= 1'b0;
        end else begin
            qtr_pulse  <= fire && (step_q != STEP5);
            half_pulse <= fire && (five_q ? (step_q == STEP1 || step_q == STEP3)
                                          : (step_q == STEP2 || step_q == STEP4));
        end
    end

    fseq_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n),
        .window(irq_ok && (cnt_q <= CNT_W'(1))),
        .fire4(irq_ok && (cnt_q == '0)),
        .wr(mode_wr),
        .wr_inhibit(mode_wr && mode_data[INHIBIT_BIT]),
        .ack(irq_ack),
        .flag(irq_flag)
    );
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic [7:0] mode_data,
    input logic       irq_ack,
    input logic       qtr_pulse,
    input logic       half_pulse,
    input logic       irq_flag
);
    AST_QTR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        qtr_pulse |=> !qtr_pulse); // R10

    AST_HALF_WITH_QTR: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |-> qtr_pulse); // R10

    AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_data[6]) |=> !irq_flag); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_ack && !mode_wr) |=> irq_flag); // R5

    AST_FIVE_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_data[7]) ##1 !mode_wr |=> (qtr_pulse && half_pulse)); // R3

    AST_IRQ_LEADS_STEP4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_flag) && !mode_wr) |=> (qtr_pulse && half_pulse)); // R5
endmodule

bind fseq_top fseq_chk u_chk (.*);

// File: tb/sim_fseq_top.sv
`timescale 1ns/1ps
module sim_fseq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pal_sel = 1'b1;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_data = 8'h00;
    logic       irq_ack = 1'b0;
    logic       qtr_pulse, half_pulse, irq_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fseq_top u0 (
        .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .mode_wr(mode_wr),
        .mode_data(mode_data), .irq_ack(irq_ack), .qtr_pulse(qtr_pulse),
        .half_pulse(half_pulse), .irq_flag(irq_flag)
    );

    function automatic int bdelay(input bit pal, input bit five, input int k);
        int d4n[5] = '{7459, 7456, 7458, 7458, 7458};
        int d4p[5] = '{8315, 8314, 8312, 8314, 8314};
        int d5n[6] = '{1, 7458, 7456, 7458, 7458, 7452};
        int d5p[6] = '{1, 8314, 8314, 8312, 8314, 8312};
        if (five) return pal ? d5p[k] : d5n[k];
        return pal ? d4p[k] : d4n[k];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] data, input bit pal);
        pal_sel   = pal;
        mode_wr   = 1'b1;
        mode_data = data;
        @(posedge clk);
        @(negedge clk);
        mode_wr   = 1'b0;
    endtask

    // irqm: 0 flag follows step 4, 1 acks around the window, 2 inhibited
    task automatic run_cfg(input string tag, input bit pal, input bit five,
                           input int ncyc, input int irqm);
        int nsteps = five ? 5 : 4;
        int next_t = bdelay(pal, five, 0);
        int t4 = bdelay(pal, five, 0) + bdelay(pal, five, 1)
               + bdelay(pal, five, 2) + bdelay(pal, five, 3);
        int k = 0;
        int bad_q = 0, bad_h = 0, bad_i = 0;
        int nq = -1, nh = -1, ni = -1;
        int aq = 0, eq = 0, ah = 0, eh = 0, ai = 0, ei = 0;
        pal_sel = !pal; // R9: change after sampling must be ignored
        for (int n = 1; n <= ncyc; n++) begin
            bit exp_q = 1'b0, exp_h = 1'b0, exp_i = 1'b0;
            irq_ack = (irqm == 1) && (n == t4 - 1 || n == t4 + 1 || n == t4 + 2);
            @(posedge clk);
            @(negedge clk);
            irq_ack = 1'b0;
            if (n == next_t) begin
                int s = (k % nsteps) + 1;
                exp_q = (s <= 4);
                exp_h = five ? (s == 1 || s == 3) : (s == 2 || s == 4);
                next_t += bdelay(pal, five, s);
                k++;
            end
            if (!five && irqm == 0) exp_i = (n >= t4 - 1);
            if (!five && irqm == 1) exp_i = (n >= t4 - 1) && (n <= t4 + 1);
            if (qtr_pulse != exp_q) begin
                if (bad_q == 0) begin nq = n; aq = qtr_pulse; eq = exp_q; end
                bad_q++;
            end
            if (half_pulse != exp_h) begin
                if (bad_h == 0) begin nh = n; ah = half_pulse; eh = exp_h; end
                bad_h++;
            end
            if (irq_flag != exp_i) begin
                if (bad_i == 0) begin ni = n; ai = irq_flag; ei = exp_i; end
                bad_i++;
            end
        end
        checks += 3;
        if (bad_q != 0) begin
            errors++;
            $display("FAIL %s qtr_pulse at cycle %0d: actual %0d expected %0d", tag, nq, aq, eq);
        end
        if (bad_h != 0) begin
            errors++;
            $display("FAIL %s half_pulse at cycle %0d: actual %0d expected %0d", tag, nh, ah, eh);
        end
        if (bad_i != 0) begin
            errors++;
            $display("FAIL %s irq_flag at cycle %0d: actual %0d expected %0d", tag, ni, ai, ei);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset qtr_pulse", qtr_pulse, 0);
        check("R8 reset half_pulse", half_pulse, 0);
        check("R8 reset irq_flag", irq_flag, 0);
        rst_n = 1'b1;
        // R8 R1 R2 R5 R9: reset behaves as a 4-step write, 50 Hz, through wrap
        run_cfg("R1 R2 R5 R8 R9 4-step 50Hz from reset", 1'b1, 1'b0, 41570, 0);
        check("R5 flag still pending before inhibit write", irq_flag, 1);
        // R6: inhibit write clears pending flag at once, then nothing sets it
        do_write(8'h40, 1'b0);
        check("R6 inhibit write clears flag", irq_flag, 0);
        run_cfg("R1 R2 R6 R7 4-step 60Hz inhibited", 1'b0, 1'b0, 29840, 2);
        // R5: acks inside the three-edge window are overridden, after it clear
        do_write(8'h00, 1'b0);
        run_cfg("R1 R2 R5 R7 4-step 60Hz ack window", 1'b0, 1'b0, 29840, 1);
        // R3 R4 R7: five-step, restarting mid-sequence
        do_write(8'hC0, 1'b0);
        run_cfg("R3 R4 R7 R9 5-step 60Hz", 1'b0, 1'b1, 37284, 0);
        do_write(8'h80, 1'b1);
        run_cfg("R3 R4 R10 5-step 50Hz", 1'b1, 1'b1, 33260, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule